// File: doc/BRIEF.md
# Pulse Width Modulator with Register Interface

This block produces one pulse-width-modulated output whose period and high time are set through three registers on a plain synchronous read/write port. A control register turns the generator on, picks which of two clock-enable strobes drives it, sets a 12-bit prescaler, and decides whether counting goes on while the chip sits in a doze, wait or debug state. A duty register gives the number of prescaled ticks per period during which the output is high. A period register sets the period length.

Each accepted strobe from the chosen source is divided by the prescaler. Every prescaled tick advances a 16-bit period counter. The output is high while that counter is below the active duty value. Duty and period writes go to shadow copies, which take them up only when a period ends. The output therefore never shows a half-old, half-new period. Software writes the period and duty values, then sets the enable bit. It can change duty at any time without glitches.

Top module: `pwm_periph`

## Requirements
- R1: After reset the control, duty and period registers all read zero and `pwm_out` is low.
- R2: Byte offset 0x00 holds control, 0x0C holds duty and 0x10 holds period. Control keeps bit 0 (enable), bits 15:4 (prescaler code), bits 17:16 (source), bit 22 (debug run), bit 23 (wait run) and bit 24 (doze run). Duty and period keep bits 15:0. Every other bit, and every other offset, reads as zero.
- R3: With duty value S and period value P, the output is high for min(S, P+2) of every P+2 prescaled ticks. S = 0 gives a constantly low output. S >= P+2 gives a constantly high output.
- R4: Prescaler code C makes each period-counter step last C+1 accepted source strobes.
- R5: Source code 1 counts on `bus_tick_en`. Source code 2 counts on `fast_tick_en`. Codes 0 and 3 never count, so the output holds its level.
- R6: While `mode_doze`, `mode_wait` or `mode_debug` is high and the matching run bit is clear, counting freezes and the output holds its level. With the run bit set, counting goes on.
- R7: Duty and period writes read back at once. While enabled, they take effect only when the counter wraps at the end of a period. While disabled, the active copies follow the registers.
- R8: Clearing the enable bit drives `pwm_out` low from the cycle after the write and resets the counter and prescaler. After re-enabling, the first period starts at count zero.
- R9: The period counter is 16 bits wide. Period values 0xFFFE and 0xFFFF both give a period of 65536 prescaled ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, same cycle |
| bus_tick_en | input | 1 | Clock-enable strobe for source code 1 |
| fast_tick_en | input | 1 | Clock-enable strobe for source code 2 |
| mode_doze | input | 1 | Chip is in doze state |
| mode_wait | input | 1 | Chip is in wait state |
| mode_debug | input | 1 | Chip is halted for debug |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench measures high time and rising edges over windows of whole periods. This result does not depend on phase, so an off-by-one in the P+2 period length or in the prescaler divide shows up as a wrong high count. It targets duty of zero, duty at or above the period and the saturated 16-bit period; a bad comparison there would give a spurious pulse or a count that runs past 65535. It writes a larger duty value just after a period begins and checks that the output stays low until the wrap; a design without shadow copies would go high at once. It also freezes the count through each low-power input, through the empty source codes and on disable, where a design that ignores the run bits keeps toggling and one that does not reset its counter restarts mid-period.

// File: rtl/pwm_periph_pkg.sv
package pwm_periph_pkg;

    localparam int PRE_W = 12;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_DUTY = 'h0C;
    localparam int OFF_PER  = 'h10;

    localparam int EN_BIT   = 0;
    localparam int PRE_LSB  = 4;
    localparam int SRC_LSB  = 16;
    localparam int DBG_BIT  = 22;
    localparam int WAIT_BIT = 23;
    localparam int DOZE_BIT = 24;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_BUS  = 2'd1,
        SRC_FAST = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    typedef struct packed {
        logic             doze_run;
        logic             wait_run;
        logic             dbg_run;
        src_e             src;
        logic [PRE_W-1:0] pre;
        logic             en;
    } ctrl_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_periph_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  duty,
    output logic [CNT_W-1:0]  per
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(OFF_DUTY);
    localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(OFF_PER);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] per;
    } regs_s;

    regs_s r_d, r_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                A_CTRL: begin
                    r_d.ctrl.en       = wdata[EN_BIT];
                    r_d.ctrl.pre      = wdata[PRE_LSB +: PRE_W];
                    r_d.ctrl.src      = src_e'(wdata[SRC_LSB +: 2]);
                    r_d.ctrl.dbg_run  = wdata[DBG_BIT];
                    r_d.ctrl.wait_run = wdata[WAIT_BIT];
                    r_d.ctrl.doze_run = wdata[DOZE_BIT];
                end
                A_DUTY:  r_d.duty = wdata[CNT_W-1:0];
                A_PER:   r_d.per  = wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[EN_BIT]             = r_q.ctrl.en;
                rdata[PRE_LSB +: PRE_W]   = r_q.ctrl.pre;
                rdata[SRC_LSB +: 2]       = r_q.ctrl.src;
                rdata[DBG_BIT]            = r_q.ctrl.dbg_run;
                rdata[WAIT_BIT]           = r_q.ctrl.wait_run;
                rdata[DOZE_BIT]           = r_q.ctrl.doze_run;
            end
            A_DUTY:  rdata[CNT_W-1:0] = r_q.duty;
            A_PER:   rdata[CNT_W-1:0] = r_q.per;
            default: ;
        endcase
    end

    assign ctrl = r_q.ctrl;
    assign duty = r_q.duty;
    assign per  = r_q.per;

endmodule

// File: rtl/pwm_tick.sv
module pwm_tick
    import pwm_periph_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  bus_tick_en,
    input  logic  fast_tick_en,
    input  logic  mode_doze,
    input  logic  mode_wait,
    input  logic  mode_debug,
    output logic  ptick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } tick_s;

    tick_s t_d, t_q;
    logic  src_en;
    logic  frozen;
    logic  adv;

    always_comb begin
        case (ctrl.src)
            SRC_BUS:  src_en = bus_tick_en;
            SRC_FAST: src_en = fast_tick_en;
            default:  src_en = 1'b0;
        endcase
        frozen = (mode_doze  && !ctrl.doze_run) ||
                 (mode_wait  && !ctrl.wait_run) ||
                 (mode_debug && !ctrl.dbg_run);
        adv    = ctrl.en && src_en && !frozen;
        ptick  = adv && (t_q.pre >= ctrl.pre);

        t_d = t_q;
        if (!ctrl.en)   t_d.pre = '0;
        else if (ptick) t_d.pre = '0;
        else if (adv)   t_d.pre = t_q.pre + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ptick,
    input  logic [CNT_W-1:0] duty_reg,
    input  logic [CNT_W-1:0] per_reg,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] duty_sh,
    output logic [CNT_W-1:0] per_sh,
    output logic             wrap,
    output logic             pwm_out
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] duty_sh;
        logic [CNT_W-1:0] per_sh;
    } cnt_s;

    cnt_s c_d, c_q;
    logic [CNT_W:0]   lim;
    logic [CNT_W-1:0] last;

    always_comb begin
        // period spans per+2 ticks: count 0 .. per+1, saturated at the counter width
        lim  = {1'b0, c_q.per_sh} + 1'b1;
        last = lim[CNT_W] ? '1 : lim[CNT_W-1:0];
        wrap = ptick && (c_q.cnt >= last);

        c_d = c_q;
        if (!en) begin
            c_d.cnt     = '0;
            c_d.duty_sh = duty_reg;
            c_d.per_sh  = per_reg;
        end else if (wrap) begin
            c_d.cnt     = '0;
            c_d.duty_sh = duty_reg;
            c_d.per_sh  = per_reg;
        end else if (ptick) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt     = c_q.cnt;
    assign duty_sh = c_q.duty_sh;
    assign per_sh  = c_q.per_sh;
    assign pwm_out = en && (c_q.cnt < c_q.duty_sh);

endmodule

// File: rtl/pwm_periph.sv
module pwm_periph
    import pwm_periph_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_tick_en,
    input  logic              fast_tick_en,
    input  logic              mode_doze,
    input  logic              mode_wait,
    input  logic              mode_debug,
    output logic              pwm_out
);

    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] duty_w;
    logic [CNT_W-1:0] per_w;
    logic             en_w;
    logic             ptick_w;
    logic             wrap_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] duty_sh_w;
    logic [CNT_W-1:0] per_sh_w;

    pwm_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .we    (bus_we),
        .rdata (bus_rdata),
        .ctrl  (ctrl_w),
        .duty  (duty_w),
        .per   (per_w)
    );

    assign en_w = ctrl_w.en;

    pwm_tick i_tick (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl         (ctrl_w),
        .bus_tick_en  (bus_tick_en),
        .fast_tick_en (fast_tick_en),
        .mode_doze    (mode_doze),
        .mode_wait    (mode_wait),
        .mode_debug   (mode_debug),
        .ptick        (ptick_w)
    );

    pwm_count #(
        .CNT_W (CNT_W)
    ) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .ptick    (ptick_w),
        .duty_reg (duty_w),
        .per_reg  (per_w),
        .cnt      (cnt_w),
        .duty_sh  (duty_sh_w),
        .per_sh   (per_sh_w),
        .wrap     (wrap_w),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm_periph_chk.sv
module pwm_periph_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ptick,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] duty_sh,
    input logic [CNT_W-1:0] per_sh,
    input logic             pwm_out
);

    // R8
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_out);

    // R8
    off_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    // R5 R6
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ptick) |=> (!en || $stable(cnt)));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> ($stable(duty_sh) && $stable(per_sh)));

    // R3
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sh == '0) |-> !pwm_out);

    // R9
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} <= ({1'b0, per_sh} + 1'b1)));

endmodule

bind pwm_periph pwm_periph_chk #(.CNT_W(CNT_W)) i_pwm_periph_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_w),
    .ptick   (ptick_w),
    .wrap    (wrap_w),
    .cnt     (cnt_w),
    .duty_sh (duty_sh_w),
    .per_sh  (per_sh_w),
    .pwm_out (pwm_out)
);

// File: tb/test_pwm_periph.sv
module test_pwm_periph;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int K      = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_tick_en = 1'b0;
    logic              fast_tick_en = 1'b1;
    logic              mode_doze = 1'b0;
    logic              mode_wait = 1'b0;
    logic              mode_debug = 1'b0;
    logic              pwm_out;
    logic              bus_toggle = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_periph i_pwm_periph (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .bus_rdata    (bus_rdata),
        .bus_tick_en  (bus_tick_en),
        .fast_tick_en (fast_tick_en),
        .mode_doze    (mode_doze),
        .mode_wait    (mode_wait),
        .mode_debug   (mode_debug),
        .pwm_out      (pwm_out)
    );

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_DUTY = 5'h0C;
    localparam logic [ADDR_W-1:0] A_PER  = 5'h10;

    typedef struct packed {
        logic [11:0] pre;
        logic [15:0] per;
        logic [15:0] duty;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{12'd0, 16'd6,  16'd3},
        '{12'd2, 16'd3,  16'd2},
        '{12'd0, 16'd0,  16'd1},
        '{12'd1, 16'd4,  16'd10},
        '{12'd0, 16'd5,  16'd0},
        '{12'd3, 16'd2,  16'd3}
    };

    function automatic logic [31:0] mk_ctrl(input logic en, input int pre,
                                            input int src, input logic [2:0] runs);
        logic [31:0] v;
        v = '0;
        v[0]     = en;
        v[15:4]  = pre[11:0];
        v[17:16] = src[1:0];
        v[22]    = runs[0];
        v[23]    = runs[1];
        v[24]    = runs[2];
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; the write is captured at the next posedge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(input int cycles, output int highs, output int rises);
        logic prev;
        prev  = pwm_out;
        highs = 0;
        rises = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (bus_toggle) bus_tick_en = ~bus_tick_en;
            else            bus_tick_en = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int highs, rises, ticks, len, win, hexp, rexp;

        repeat (3) @(negedge clk);
        // R1 reset state
        rd(A_CTRL, d); chk("R1 ctrl reset", int'(d), 0);
        rd(A_DUTY, d); chk("R1 duty reset", int'(d), 0);
        rd(A_PER,  d); chk("R1 per reset",  int'(d), 0);
        chk("R1 out reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 readback masks
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d); chk("R2 ctrl mask", int'(d), int'(32'h01C3_FFF1));
        wr(A_CTRL, 32'h0);
        wr(A_DUTY, 32'hFFFF_FFFF);
        rd(A_DUTY, d); chk("R2 duty mask", int'(d), int'(32'h0000_FFFF));
        wr(A_PER, 32'hABCD_1234);
        rd(A_PER, d);  chk("R2 per mask", int'(d), int'(32'h0000_1234));
        rd(5'h04, d);  chk("R2 hole reads zero", int'(d), 0);

        // R3 R4 table of whole-period measurements
        for (int v = 0; v < NV; v++) begin
            wr(A_CTRL, 32'h0);
            wr(A_PER,  {16'h0, VEC[v].per});
            wr(A_DUTY, {16'h0, VEC[v].duty});
            wr(A_CTRL, mk_ctrl(1'b1, int'(VEC[v].pre), 2, 3'b000));
            ticks = int'(VEC[v].per) + 2;
            len   = int'(VEC[v].pre) + 1;
            win   = ticks * len * K;
            hexp  = ((int'(VEC[v].duty) < ticks) ? int'(VEC[v].duty) : ticks) * len * K;
            rexp  = (VEC[v].duty == 0 || int'(VEC[v].duty) >= ticks) ? 0 : K;
            measure(win, highs, rises);
            measure(win, highs, rises);
            chk($sformatf("R3 R4 vec%0d high time", v), highs, hexp);
            chk($sformatf("R3 vec%0d periods", v), rises, rexp);
        end

        // R5 source code 0 holds the counter
        wr(A_CTRL, 32'h0);
        wr(A_PER, 32'd6);
        wr(A_DUTY, 32'd3);
        wr(A_CTRL, mk_ctrl(1'b1, 0, 0, 3'b000));
        measure(30, highs, rises);
        chk("R5 src0 holds", highs, 30);
        wr(A_CTRL, mk_ctrl(1'b1, 0, 3, 3'b000));
        measure(30, highs, rises);
        chk("R5 src3 holds", highs, 30);

        // R5 source code 1 uses bus strobe at half rate
        wr(A_CTRL, 32'h0);
        fast_tick_en = 1'b0;
        bus_toggle   = 1'b1;
        wr(A_CTRL, mk_ctrl(1'b1, 0, 1, 3'b000));
        measure(48, highs, rises);
        measure(48, highs, rises);
        chk("R5 bus source high time", highs, 18);
        bus_toggle   = 1'b0;
        fast_tick_en = 1'b1;

        // R6 low-power modes
        for (int m = 0; m < 3; m++) begin
            logic [2:0] run;
            run = 3'b001 << m;
            wr(A_CTRL, 32'h0);
            wr(A_CTRL, mk_ctrl(1'b1, 0, 2, 3'b000));
            repeat (5) @(negedge clk);
            mode_debug = (m == 0);
            mode_wait  = (m == 1);
            mode_doze  = (m == 2);
            measure(40, highs, rises);
            chk($sformatf("R6 mode%0d frozen rises", m), rises, 0);
            chk($sformatf("R6 mode%0d frozen level", m), int'(highs == 0 || highs == 40), 1);
            wr(A_CTRL, mk_ctrl(1'b1, 0, 2, run));
            measure(40, highs, rises);
            chk($sformatf("R6 mode%0d running", m), int'(rises >= 4), 1);
            mode_debug = 1'b0;
            mode_wait  = 1'b0;
            mode_doze  = 1'b0;
        end

        // R8 disable forces low, re-enable starts at count zero
        wr(A_CTRL, 32'h0);
        wr(A_DUTY, 32'd20);
        wr(A_CTRL, mk_ctrl(1'b1, 0, 2, 3'b000));
        repeat (3) @(negedge clk);
        chk("R8 running high", int'(pwm_out), 1);
        wr(A_CTRL, 32'h0);
        chk("R8 disabled low", int'(pwm_out), 0);
        wr(A_DUTY, 32'd1);
        wr(A_CTRL, mk_ctrl(1'b1, 0, 2, 3'b000));
        chk("R8 first tick high", int'(pwm_out), 1);
        @(negedge clk);
        chk("R8 second tick low", int'(pwm_out), 0);

        // R7 duty change deferred to the wrap
        begin
            logic prev;
            int   lows;
            prev = pwm_out;
            @(negedge clk);
            while (!(pwm_out && !prev)) begin
                prev = pwm_out;
                @(negedge clk);
            end
            wr(A_DUTY, 32'd7);
            rd(A_DUTY, d);
            chk("R7 readback immediate", int'(d), 7);
            lows = 0;
            for (int i = 0; i < 7; i++) begin
                if (!pwm_out) lows++;
                @(negedge clk);
            end
            chk("R7 old duty until wrap", lows, 7);
            chk("R7 new duty after wrap", int'(pwm_out), 1);
        end

        // R9 saturated period
        wr(A_CTRL, 32'h0);
        wr(A_PER, 32'h0000_FFFF);
        wr(A_DUTY, 32'h0000_8000);
        wr(A_CTRL, mk_ctrl(1'b1, 0, 2, 3'b000));
        measure(65536, highs, rises);
        chk("R9 max period high time", highs, 32768);
        chk("R9 max period one pulse", rises, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule